// File: doc/BRIEF.md
# Clock Configuration Register Bank

This block keeps the control state of a system clock generator and turns it into the active operating configuration. When reset ends, it captures three frequency-select strap pins once and holds them. Software then changes the settings through a plain byte-addressed write port and reads them back through the same address. The serial front end, the PLL and the frequency synthesis sit outside this block.

The block has three registers. A clock-gate byte at address 4 and a PCI-gate byte at address 5 each give one enable bit per output clock. A mode byte at address 6 holds the software frequency fields, the spread-spectrum bit and the SDRAM reference enable. It also holds a source bit that chooses where the frequency index and the spread enable come from: the latched straps and the spread pin, or the register fields.

The strap sequencing is a two-state machine. `CFG_WAIT` is entered on reset. `CFG_CAPTURE_DONE` is the transition taken on the first clock after reset ends, and it enters `CFG_RUN`, which holds until the next reset. No other transition exists.

Top module: `clkcfg_regbank`

## Requirements
- R1: During reset and up to the capture edge, the clock-gate byte (address 4) and the PCI-gate byte (address 5) read 8'hFF. The mode byte (address 6) reads 8'h01: spread bit 7 = 0, fields 6:2 = 0, source bit 1 = 0, SDRAM bit 0 = 1.
- R2: On the first rising clock after rst_n goes high, the FSM moves from CFG_WAIT to CFG_RUN and latches strap_fs. The same value is loaded into mode byte bits 6:4. The latch then ignores the strap pins until the next reset.
- R3: A write presented on the capture edge, while the FSM is in CFG_WAIT, is ignored.
- R4: With source bit (mode byte bit 1) = 0, freq_idx = {2'b00, latched straps}. Straps 000 give index 0, which is the 133.33/33.33/66.67 MHz CPU/PCI/AGP setting.
- R5: With source bit = 1, freq_idx = {mode byte bits 3:2, mode byte bits 6:4}.
- R6: With source bit = 0, spread_en = !spread_n. With source bit = 1, spread_en = mode byte bit 7.
- R7: sdram_en equals mode byte bit 0.
- R8: Clock-gate byte mapping: bit 7 gives ref_en[0], bit 6 gives en_24_48, bit 5 gives en_48, bit 4 gives agp_en[1], bit 3 gives agp_en[0], and bits 2..0 give cpu_en[2..0]. A value of 1 enables the output.
- R9: PCI-gate byte mapping: bit 7 gives ref_en[1], and bits 6..0 give pci_en[6..0]. A value of 1 enables the output.
- R10: A write to any address other than 4, 5 or 6 changes no register. A read of such an address returns 8'h00.
- R11: rd_data returns the contents of the register at addr in the same cycle. A write is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fs | input | 3 | Frequency-select strap pins |
| spread_n | input | 1 | Active-low spread request pin, used in strap mode |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| freq_idx | output | 5 | Resolved frequency-table index |
| spread_en | output | 1 | Resolved spread-spectrum enable |
| sdram_en | output | 1 | SDRAM reference enable |
| ref_en | output | 2 | Reference clock enables |
| en_48 | output | 1 | 48 MHz enable |
| en_24_48 | output | 1 | 24/48 MHz enable |
| agp_en | output | 2 | AGP clock enables |
| cpu_en | output | 3 | CPU pair enables |
| pci_en | output | 7 | PCI clock enables |

## Verification
A strap latch that fails to capture, or that keeps following the pins, shows up on freq_idx in strap mode. It appears in the cycle after the capture edge or in the cycle after the pins change. An FSM stuck in CFG_WAIT drops every write, so the next read-back of the written byte differs one cycle after that write. A wrong field position in the resolver shows up at once on freq_idx, spread_en or an enable pin.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    typedef enum logic {
        CFG_WAIT = 1'b0,
        CFG_RUN  = 1'b1
    } cfg_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/clkcfg_strap_fsm.sv
module clkcfg_strap_fsm
    import clkcfg_pkg::*;
#(
    parameter int FS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] strap_fs,
    output logic            capture,
    output logic            run,
    output logic [FS_W-1:0] strap_q
);
    cfg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_WAIT;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        run     = 1'b0;
        unique case (state_q)
            CFG_WAIT: begin
                capture = 1'b1;
                state_d = CFG_RUN;   // CFG_CAPTURE_DONE
            end
            CFG_RUN: begin
                run = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       strap_q <= '0;
        else if (capture) strap_q <= strap_fs;
    end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int FS_W     = 3,
    parameter int A_CLK    = 4,
    parameter int A_PCI    = 5,
    parameter int A_MODE   = 6,
    parameter int FS_LSB   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              run,
    input  logic [FS_W-1:0]   strap_fs,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] clk_reg,
    output logic [BYTE_W-1:0] pci_reg,
    output logic [BYTE_W-1:0] mode_reg
);
    localparam logic [BYTE_W-1:0] MODE_RST = 8'h01;
    localparam int FS_MSB = FS_LSB + FS_W - 1;

    logic hit_clk, hit_pci, hit_mode;
    assign hit_clk  = (addr == ADDR_W'(A_CLK));
    assign hit_pci  = (addr == ADDR_W'(A_PCI));
    assign hit_mode = (addr == ADDR_W'(A_MODE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_reg  <= '1;
            pci_reg  <= '1;
            mode_reg <= MODE_RST;
        end else if (capture) begin
            mode_reg[FS_MSB:FS_LSB] <= strap_fs;
        end else if (run && wr_en) begin
            if (hit_clk)  clk_reg  <= wr_data;
            if (hit_pci)  pci_reg  <= wr_data;
            if (hit_mode) mode_reg <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit_clk)  rd_data = clk_reg;
        if (hit_pci)  rd_data = pci_reg;
        if (hit_mode) rd_data = mode_reg;
    end
endmodule

// File: rtl/clkcfg_resolve.sv
module clkcfg_resolve
    import clkcfg_pkg::*;
#(
    parameter int FS_W  = 3,
    parameter int HI_W  = 2,
    parameter int PCI_N = 7,
    parameter int CPU_N = 3,
    localparam int IDX_W = FS_W + HI_W
) (
    input  logic [BYTE_W-1:0] clk_reg,
    input  logic [BYTE_W-1:0] pci_reg,
    input  logic [BYTE_W-1:0] mode_reg,
    input  logic [FS_W-1:0]   strap_q,
    input  logic              spread_n,
    output logic [IDX_W-1:0]  freq_idx,
    output logic              spread_en,
    output logic              sdram_en,
    output logic [1:0]        ref_en,
    output logic              en_48,
    output logic              en_24_48,
    output logic [1:0]        agp_en,
    output logic [CPU_N-1:0]  cpu_en,
    output logic [PCI_N-1:0]  pci_en
);
    logic sw_src;
    assign sw_src = mode_reg[1];

    always_comb begin
        if (sw_src) begin
            freq_idx  = {mode_reg[3:2], mode_reg[6:4]};
            spread_en = mode_reg[7];
        end else begin
            freq_idx  = {{HI_W{1'b0}}, strap_q};
            spread_en = ~spread_n;
        end
    end

    assign sdram_en  = mode_reg[0];
    assign ref_en[0] = clk_reg[7];
    assign en_24_48  = clk_reg[6];
    assign en_48     = clk_reg[5];
    assign agp_en    = clk_reg[4:3];
    assign ref_en[1] = pci_reg[7];

    for (genvar i = 0; i < CPU_N; i++) begin : g_cpu
        assign cpu_en[i] = clk_reg[i];
    end
    for (genvar j = 0; j < PCI_N; j++) begin : g_pci
        assign pci_en[j] = pci_reg[j];
    end
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int FS_W   = 3,
    parameter int HI_W   = 2,
    parameter int PCI_N  = 7,
    parameter int CPU_N  = 3,
    localparam int IDX_W = FS_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FS_W-1:0]   strap_fs,
    input  logic              spread_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [IDX_W-1:0]  freq_idx,
    output logic              spread_en,
    output logic              sdram_en,
    output logic [1:0]        ref_en,
    output logic              en_48,
    output logic              en_24_48,
    output logic [1:0]        agp_en,
    output logic [CPU_N-1:0]  cpu_en,
    output logic [PCI_N-1:0]  pci_en
);
    logic            capture, run;
    logic [FS_W-1:0] strap_q;
    logic [7:0]      clk_reg, pci_reg, mode_reg;

    clkcfg_strap_fsm #(.FS_W(FS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs),
        .capture(capture), .run(run), .strap_q(strap_q)
    );

    clkcfg_regs #(.ADDR_W(ADDR_W), .FS_W(FS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .capture(capture), .run(run),
        .strap_fs(strap_fs), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .clk_reg(clk_reg), .pci_reg(pci_reg),
        .mode_reg(mode_reg)
    );

    clkcfg_resolve #(.FS_W(FS_W), .HI_W(HI_W), .PCI_N(PCI_N), .CPU_N(CPU_N)) u_res (
        .clk_reg(clk_reg), .pci_reg(pci_reg), .mode_reg(mode_reg),
        .strap_q(strap_q), .spread_n(spread_n), .freq_idx(freq_idx),
        .spread_en(spread_en), .sdram_en(sdram_en), .ref_en(ref_en),
        .en_48(en_48), .en_24_48(en_24_48), .agp_en(agp_en),
        .cpu_en(cpu_en), .pci_en(pci_en)
    );
endmodule

// File: rtl/clkcfg_checker.sv
module clkcfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic [2:0] strap_q,
    input logic [7:0] clk_reg,
    input logic [7:0] pci_reg,
    input logic [7:0] mode_reg,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic       spread_n,
    input logic [4:0] freq_idx,
    input logic       spread_en
);
    // R2: leaves CFG_WAIT after one edge
    assert_capture_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> run);

    // R2: latched straps stay fixed while running
    assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(strap_q));

    // R4: strap mode puts zeros in the upper index bits
    assert_hw_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_reg[1] |-> (freq_idx[4:3] == 2'b00 && freq_idx[2:0] == strap_q));

    // R6: strap mode follows the spread pin
    assert_hw_spread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_reg[1] |-> (spread_en == !spread_n));

    // R10: undefined address writes leave every register alone
    assert_undef_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && addr != 8'd4 && addr != 8'd5 && addr != 8'd6)
        |=> ($stable(clk_reg) && $stable(pci_reg) && $stable(mode_reg)));
endmodule

bind clkcfg_regbank clkcfg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .strap_q(strap_q),
    .clk_reg(clk_reg), .pci_reg(pci_reg), .mode_reg(mode_reg),
    .wr_en(wr_en), .addr(addr), .spread_n(spread_n),
    .freq_idx(freq_idx), .spread_en(spread_en)
);

// File: tb/clkcfg_regbank_bench.sv
module clkcfg_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    // {addr, wdata, exp_idx, exp_spread, exp_rd} with straps 101, spread_n=1
    localparam logic [39:0] VEC [5] = '{
        {8'd6, 8'hBA, 8'h13, 8'h01, 8'hBA},  // R5 R6 sw source
        {8'd6, 8'h38, 8'h05, 8'h00, 8'h38},  // R4 R6 strap source
        {8'd6, 8'h7E, 8'h1F, 8'h00, 8'h7E},  // R5 max index
        {8'd6, 8'h02, 8'h00, 8'h00, 8'h02},  // R5 zero index
        {8'd7, 8'hFF, 8'h00, 8'h00, 8'h00}   // R10 undefined address
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap_fs = 3'b101;
    logic       spread_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic [4:0] freq_idx;
    logic       spread_en, sdram_en, en_48, en_24_48;
    logic [1:0] ref_en, agp_en;
    logic [2:0] cpu_en;
    logic [6:0] pci_en;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_regbank u_clkcfg_regbank (
        .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .spread_n(spread_n),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .freq_idx(freq_idx), .spread_en(spread_en), .sdram_en(sdram_en),
        .ref_en(ref_en), .en_48(en_48), .en_24_48(en_24_48), .agp_en(agp_en),
        .cpu_en(cpu_en), .pci_en(pci_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(req, {24'd0, rd_data}, {24'd0, exp});
    endtask

    task automatic do_reset(input logic [2:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_fs = s;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: reset values, before the capture edge
        do_reset(3'b101);
        rd_chk("R1 clk byte", 8'd4, 8'hFF);
        rd_chk("R1 pci byte", 8'd5, 8'hFF);
        rd_chk("R1 mode byte", 8'd6, 8'h01);
        // R3: a write on the capture edge is dropped
        wr_en = 1'b1; addr = 8'd4; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk("R3 capture write dropped", 8'd4, 8'hFF);
        rd_chk("R2 fs loaded into mode byte", 8'd6, 8'h51);
        chk("R4 strap index", {27'd0, freq_idx}, 32'h05);
        chk("R7 sdram default", {31'd0, sdram_en}, 32'd1);
        // R2: pins ignored after capture
        strap_fs = 3'b010;
        @(negedge clk);
        chk("R2 latch holds", {27'd0, freq_idx}, 32'h05);

        // vector table: R5 R6 R10 R11
        for (int i = 0; i < 5; i++) begin
            wr(VEC[i][39:32], VEC[i][31:24]);
            #1;
            chk("R5 vector index", {27'd0, freq_idx}, {27'd0, VEC[i][20:16]});
            chk("R6 vector spread", {31'd0, spread_en}, {31'd0, VEC[i][8]});
            rd_chk("R11 vector readback", VEC[i][39:32], VEC[i][7:0]);
        end
        rd_chk("R10 mode byte unchanged", 8'd6, 8'h02);
        rd_chk("R10 undefined read", 8'd9, 8'h00);
        chk("R7 sdram off", {31'd0, sdram_en}, 32'd0);

        wr(8'd6, 8'h03);
        #1;
        chk("R7 sdram on", {31'd0, sdram_en}, 32'd1);

        // R6: strap mode uses spread pin
        wr(8'd6, 8'h00);
        spread_n = 1'b0;
        #1;
        chk("R6 pin low spreads", {31'd0, spread_en}, 32'd1);
        spread_n = 1'b1;

        // R8 clock-gate byte
        wr(8'd4, 8'h0F);
        #1;
        chk("R8 clk enables",
            {23'd0, ref_en[0], en_24_48, en_48, agp_en, cpu_en},
            {23'd0, 1'b0, 1'b0, 1'b0, 2'b01, 3'b111});
        wr(8'd4, 8'hF0);
        #1;
        chk("R8 clk enables hi",
            {23'd0, ref_en[0], en_24_48, en_48, agp_en, cpu_en},
            {23'd0, 1'b1, 1'b1, 1'b1, 2'b10, 3'b000});

        // R9 PCI-gate byte
        wr(8'd5, 8'hA5);
        #1;
        chk("R9 pci enables", {24'd0, ref_en[1], pci_en}, {24'd0, 1'b1, 7'b0100101});

        // R4: new reset with straps 000 -> index 0, fields reset
        do_reset(3'b000);
        @(negedge clk);
        chk("R4 strap 000 index", {27'd0, freq_idx}, 32'd0);
        rd_chk("R1 mode after reset", 8'd6, 8'h01);
        rd_chk("R1 clk after reset", 8'd4, 8'hFF);

        done = 1'b1;
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule